// File: doc/BRIEF.md
# Sector Data Phase Word Sequencer

This block paces the data phase of a single disk sector. A start request arms a word counter. The counter is preset to one value for a read and to a larger value for a write. The accepted start also sends a one-cycle preset pulse to the external CRC accumulator. Each word-slot tick from the serial encoder then decrements the counter, and the decremented value selects what happens in that slot.

On a write, the block first drives the user data words. After the data comes the CRC word supplied by the accumulator, and then one zero post-amble word. The block drops write-enable on the final slot and pulses sector-done. Each data slot except the last one pulses a request to clear the host's input-buffer-full flag, so the host supplies the next word. When the transfer-complete status is set, the block pads the remaining data slots with zeros.

On a read, the counter only counts the slots. The block drives nothing and pulses sector-done on the last slot. Start requests that arrive while a sector is in progress are ignored.

Top module: `sector_data_seq`

## Requirements
- R1: After reset, `word_o`, `wr_en_o`, `ibf_clr_o`, `crc_preset_o` and `sector_done_o` are all 0 and no sector is in progress.
- R2: A start accepted while idle loads the counter with `WR_WORDS` when `op_wr_i`=1 or with `RD_WORDS` when `op_wr_i`=0. It pulses `crc_preset_o` for exactly one cycle, in the cycle after the start.
- R3: On a write, each tick decrements the counter. While the decremented count is above 2, the tick registers `data_i` onto `word_o`, visible the cycle after the tick. This gives `WR_WORDS`-3 data words in tick order.
- R4: A write data slot whose tick sees `xfer_done_i`=1 emits 0 instead of `data_i`.
- R5: The write tick that brings the count to 2 emits `crc_i` on `word_o`.
- R6: The write tick that brings the count to 1 emits a zero post-amble word.
- R7: `wr_en_o` rises the cycle after the first write tick. It stays high through the post-amble slot and falls the cycle after the tick that brings the count to 0, when `word_o` also returns to 0.
- R8: `ibf_clr_o` pulses for one cycle after each write data tick whose decremented count is above 3. The last data word raises no pulse, so a write sector gives `WR_WORDS`-4 pulses.
- R9: `sector_done_o` pulses for one cycle after the tick that brings the count to 0. That is the `WR_WORDS`-th tick of a write and the `RD_WORDS`-th tick of a read. The block is idle afterwards.
- R10: During a read, `wr_en_o` and `ibf_clr_o` stay 0 and `word_o` stays 0.
- R11: `start_i` while a sector is in progress has no effect: no `crc_preset_o` pulse, no counter reload, and the sector ends at its original tick.
- R12: `tick_i` while idle has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Sector data-phase start request |
| op_wr_i | input | 1 | Operation: 1 write, 0 read (sampled with the accepted start) |
| tick_i | input | 1 | Word-slot strobe from the serial encoder |
| data_i | input | WORD_W | Host data word for the current slot |
| xfer_done_i | input | 1 | Transfer-complete status; pads data slots with zero |
| crc_i | input | WORD_W | Value from the CRC accumulator |
| word_o | output | WORD_W | Word to serialize |
| wr_en_o | output | 1 | Write path enable |
| ibf_clr_o | output | 1 | Pulse clearing the host's input-buffer-full flag |
| crc_preset_o | output | 1 | Pulse presetting the CRC accumulator |
| sector_done_o | output | 1 | Pulse at the end of the sector |

## Verification
The bench builds the block with `RD_WORDS`=7 and `WR_WORDS`=8. A write sector is then five data words, a CRC word and a post-amble, and a read sector is seven slots. Several thousand random cycles therefore cover hundreds of complete sectors. They include ticks on consecutive cycles and with gaps, transfer-complete asserted mid-sector, and starts that collide with a sector in progress or arrive on the cycle right after sector-done. The same counts make the boundary slots recur often: the switch from data to CRC, the missing clear pulse on the last data word, and the final-tick release.

// File: rtl/sds_pkg.sv
package sds_pkg;
  typedef enum logic {
    OP_RD = 1'b0,
    OP_WR = 1'b1
  } op_e;

  typedef enum logic [1:0] {
    SLOT_DATA = 2'd0,
    SLOT_CRC  = 2'd1,
    SLOT_POST = 2'd2,
    SLOT_END  = 2'd3
  } slot_e;
endpackage

// File: rtl/sds_word_counter.sv
module sds_word_counter #(
  parameter int RD_WORDS = 129,
  parameter int WR_WORDS = 130,
  localparam int MAX_W = (RD_WORDS > WR_WORDS) ? RD_WORDS : WR_WORDS,
  localparam int CNT_W = $clog2(MAX_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             op_wr_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_nxt_o
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt_nxt_o = cnt_q - CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= op_wr_i ? CNT_W'(WR_WORDS) : CNT_W'(RD_WORDS);
    else if (dec_i)  cnt_q <= cnt_nxt_o;
  end

  // counter only moves on load or tick (R11, R12)
  assert_cnt_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !dec_i) |=> $stable(cnt_q));
  assert_no_dec_at_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> (cnt_q != '0));
endmodule

// File: rtl/sds_slot_decode.sv
module sds_slot_decode
  import sds_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic [CNT_W-1:0] cnt_nxt_i,
  output slot_e            slot_o,
  output logic             want_more_o
);
  always_comb begin
    if (cnt_nxt_i > CNT_W'(2))       slot_o = SLOT_DATA;
    else if (cnt_nxt_i == CNT_W'(2)) slot_o = SLOT_CRC;
    else if (cnt_nxt_i == CNT_W'(1)) slot_o = SLOT_POST;
    else                             slot_o = SLOT_END;
  end

  // last data word requests no refill
  assign want_more_o = cnt_nxt_i > CNT_W'(3);
endmodule

// File: rtl/sector_data_seq.sv
module sector_data_seq
  import sds_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int RD_WORDS = 129,
  parameter int WR_WORDS = 130,
  localparam int MAX_W = (RD_WORDS > WR_WORDS) ? RD_WORDS : WR_WORDS,
  localparam int CNT_W = $clog2(MAX_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              op_wr_i,
  input  logic              tick_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              xfer_done_i,
  input  logic [WORD_W-1:0] crc_i,
  output logic [WORD_W-1:0] word_o,
  output logic              wr_en_o,
  output logic              ibf_clr_o,
  output logic              crc_preset_o,
  output logic              sector_done_o
);
  logic             active_q;
  op_e              op_q;
  logic             load, dec;
  logic [CNT_W-1:0] cnt_nxt;
  slot_e            slot;
  logic             want_more;

  assign load = start_i && !active_q;
  assign dec  = tick_i && active_q;

  sds_word_counter #(.RD_WORDS(RD_WORDS), .WR_WORDS(WR_WORDS)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .op_wr_i(op_wr_i),
    .dec_i(dec), .cnt_nxt_o(cnt_nxt)
  );

  sds_slot_decode #(.CNT_W(CNT_W)) u_dec (
    .cnt_nxt_i(cnt_nxt), .slot_o(slot), .want_more_o(want_more)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q      <= 1'b0;
      op_q          <= OP_RD;
      word_o        <= '0;
      wr_en_o       <= 1'b0;
      ibf_clr_o     <= 1'b0;
      crc_preset_o  <= 1'b0;
      sector_done_o <= 1'b0;
    end else begin
      crc_preset_o  <= load;
      ibf_clr_o     <= 1'b0;
      sector_done_o <= 1'b0;
      if (load) begin
        active_q <= 1'b1;
        op_q     <= op_e'(op_wr_i);
      end else if (dec) begin
        if (slot == SLOT_END) begin
          active_q      <= 1'b0;
          sector_done_o <= 1'b1;
          wr_en_o       <= 1'b0;
          word_o        <= '0;
        end else if (op_q == OP_WR) begin
          wr_en_o <= 1'b1;
          unique case (slot)
            SLOT_DATA: begin
              word_o    <= xfer_done_i ? '0 : data_i;
              ibf_clr_o <= want_more;
            end
            SLOT_CRC:  word_o <= crc_i;
            default:   word_o <= '0;
          endcase
        end
      end
    end
  end

  assert_rd_silent_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q == OP_RD) |-> (!wr_en_o && !ibf_clr_o && word_o == '0));
  assert_clr_in_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ibf_clr_o |-> wr_en_o);
  assert_clr_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ibf_clr_o |=> !ibf_clr_o || $past(tick_i));
  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sector_done_o |=> !sector_done_o);
  assert_done_we_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sector_done_o |-> (!wr_en_o && word_o == '0));
  assert_preset_cause_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_preset_o |-> $past(start_i));
  assert_hold_between_ticks_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(word_o) && $stable(wr_en_o)));
endmodule

// File: tb/sector_data_seq_bench.sv
module sector_data_seq_bench;
  localparam int RDW = 7;
  localparam int WRW = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, op_wr_i = 1'b0, tick_i = 1'b0, xfer_done_i = 1'b0;
  logic [15:0] data_i = '0, crc_i = '0;
  logic [15:0] word_o;
  logic        wr_en_o, ibf_clr_o, crc_preset_o, sector_done_o;

  int checks = 0, fails = 0;
  bit ended = 0;

  // model state
  bit          m_act = 0, m_op = 0;
  int          m_cnt = 0;
  logic [15:0] e_word = '0;
  bit          e_we = 0, e_clr = 0, e_pre = 0, e_done = 0;
  string       tag_w, tag_we, tag_clr, tag_done, tag_pre;

  always #2 clk_i = ~clk_i;

  sector_data_seq #(.WORD_W(16), .RD_WORDS(RDW), .WR_WORDS(WRW)) u_sector_data_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_wr_i(op_wr_i),
    .tick_i(tick_i), .data_i(data_i), .xfer_done_i(xfer_done_i), .crc_i(crc_i),
    .word_o(word_o), .wr_en_o(wr_en_o), .ibf_clr_o(ibf_clr_o),
    .crc_preset_o(crc_preset_o), .sector_done_o(sector_done_o)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] data_slot(input logic [15:0] d, input bit xd);
    return xd ? 16'h0 : d;
  endfunction

  task automatic model(input bit st, input bit wr, input bit tk, input logic [15:0] d,
                       input bit xd, input logic [15:0] c);
    int n;
    e_clr = 0; e_done = 0; e_pre = 0;
    tag_w = "R3"; tag_we = "R7"; tag_clr = "R8"; tag_done = "R9"; tag_pre = "R2";
    if (m_act && st) begin tag_pre = "R11"; tag_done = "R11"; end
    if (!m_act && tk && !st) begin tag_w = "R12"; tag_we = "R12"; tag_done = "R12"; end
    if (!m_act && st) begin
      m_act = 1; m_op = wr; m_cnt = wr ? WRW : RDW; e_pre = 1;
    end else if (m_act && tk) begin
      n = m_cnt - 1; m_cnt = n;
      if (!m_op) begin tag_w = "R10"; tag_we = "R10"; tag_clr = "R10"; end
      if (n == 0) begin
        e_done = 1; e_we = 0; e_word = '0; m_act = 0;
      end else if (m_op) begin
        e_we = 1;
        if (n > 2) begin
          e_word = data_slot(d, xd); e_clr = (n > 3);
          if (xd) tag_w = "R4";
        end else if (n == 2) begin
          e_word = c; tag_w = "R5";
        end else begin
          e_word = '0; tag_w = "R6";
        end
      end
    end
  endtask

  task automatic cyc(input bit st, input bit wr, input bit tk, input logic [15:0] d,
                     input bit xd, input logic [15:0] c);
    start_i = st; op_wr_i = wr; tick_i = tk; data_i = d; xfer_done_i = xd; crc_i = c;
    model(st, wr, tk, d, xd, c);
    @(negedge clk_i);
    chk(tag_w, word_o, e_word);
    chk(tag_we, 16'(wr_en_o), 16'(e_we));
    chk(tag_clr, 16'(ibf_clr_o), 16'(e_clr));
    chk(tag_done, 16'(sector_done_o), 16'(e_done));
    chk(tag_pre, 16'(crc_preset_o), 16'(e_pre));
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int unsigned seed_init;
    seed_init = $urandom(32'h5EC7_0A11);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1", word_o, 16'h0);
    chk("R1", 16'({wr_en_o, ibf_clr_o, crc_preset_o, sector_done_o}), 16'h0);
    // R12 ticks while idle
    for (int i = 0; i < 3; i++) cyc(0, 1, 1, 16'hBEEF, 0, 16'h1234);
    // directed write sector, back-to-back ticks
    cyc(1, 1, 0, 0, 0, 0);
    for (int i = 0; i < WRW; i++) cyc(0, 0, 1, 16'hA000 + 16'(i), 0, 16'hC5C5);
    // R11 restart attempts during a read, with gaps
    cyc(1, 0, 0, 0, 0, 0);
    for (int i = 0; i < RDW; i++) begin
      cyc(1, 1, 0, 16'h1111, 0, 0);
      cyc(0, 1, 1, 16'h2222, 0, 0);
    end
    // R4 transfer complete mid-write, start on the cycle after done
    cyc(1, 1, 0, 0, 0, 0);
    for (int i = 0; i < WRW; i++) cyc(0, 0, 1, 16'h7000 + 16'(i), i >= 2, 16'h5A5A);
    cyc(1, 1, 1, 0, 0, 0);
    for (int i = 0; i < WRW; i++) cyc(0, 0, 1, 16'h3300 + 16'(i), 0, 16'h0F0F);
    // constrained random
    for (int i = 0; i < 4000; i++) begin
      cyc(($urandom % 6) == 0, $urandom % 2, $urandom % 2, 16'($urandom),
          ($urandom % 8) == 0, 16'($urandom));
    end
    finish_run();
  end
endmodule